// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 30-bit physical address. It reads a first-level page-table entry from memory, then a second-level entry, and reports the physical page number together with the page's status flags. The first-level table starts at a byte address given on the `tbl_base` input. The entry located there gives the frame that holds the second-level table. Memory is reached through a single word-wide request/acknowledge port.

A walk can end in one of three ways: a translation, a not-present fault, or a protection fault. A store that is allowed to reach a writable page whose dirty flag is still clear makes the walker write that second-level entry back with the dirty flag set before it reports the translation. Only one walk runs at a time. The `busy` output stays high from the cycle after a request is accepted until the cycle in which the outcome is reported.

Entry word layout, the same at both levels: bit 0 = present, bit 1 = dirty, bit 2 = writable (1 means read/write, 0 means read-only), bits 31:14 = 18-bit frame number. The virtual address is split as bits 31:22 = first-level index, bits 21:12 = second-level index, bits 11:0 = page offset.

Top module: `vm_walker`

## Requirements
- R1: After reset, and whenever no walk is running, `busy`, `mem_req`, `done`, `fault_absent` and `fault_denied` are all low.
- R2: The first memory read of a walk goes to byte address `tbl_base + 4 × va[31:22]`, with `mem_we` low. The request is held with a stable address until `mem_ack`.
- R3: When the first-level entry has bit 0 set, the second read goes to byte address `{entry[31:14], 12'h000} + 4 × va[21:12]`.
- R4: On a successful walk, `done` is high and `pa` = `{leaf[31:14], va[11:0]}`. `pte_dirty` and `pte_writable` reflect bits 1 and 2 of the leaf entry as it stands at the end of the walk.
- R5: A first-level entry with bit 0 clear ends the walk with `fault_absent` after exactly one memory access.
- R6: A second-level entry with bit 0 clear ends the walk with `fault_absent` after two reads, and no write is made, even for a store.
- R7: A store to a present leaf with bit 2 clear ends the walk with `fault_denied` and makes no memory write.
- R8: A store to a present, writable leaf with bit 1 clear makes exactly one write to the leaf's address, with data equal to the leaf plus bit 1 set. `done` follows, with `pte_dirty` high.
- R9: A load, or a store to a leaf whose bit 1 is already set, makes exactly two memory accesses and no write.
- R10: A request raised while `busy` is high is ignored: the running walk finishes unchanged and no further memory access follows.
- R11: Each walk reports exactly one of `done`, `fault_absent` or `fault_denied`, for a single cycle, and `busy` is low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a walk (taken only when not busy) |
| req_va | input | 32 | Virtual address to translate |
| req_store | input | 1 | 1 = store access, 0 = load |
| tbl_base | input | 30 | Byte address of the first-level table |
| busy | output | 1 | A walk is in progress |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 30 | Byte address of the entry word |
| mem_wdata | output | 32 | Write data (leaf with dirty set) |
| mem_ack | input | 1 | One-cycle acknowledge; read data valid with it |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | Translation ready (one cycle) |
| fault_absent | output | 1 | Not-present fault (one cycle) |
| fault_denied | output | 1 | Store to a read-only page (one cycle) |
| pa | output | 30 | Physical address, valid with `done` |
| pte_dirty | output | 1 | Leaf dirty flag, valid with `done` |
| pte_writable | output | 1 | Leaf writable flag, valid with `done` |

## Verification
The properties assume that the memory side raises `mem_ack` for one cycle only, and only while `mem_req` is high. They also assume that `req_valid` is sampled only when it matters, so a request during a walk has no effect. The bench memory model acknowledges each request one cycle after it appears, drops the acknowledge at once, and never acknowledges when nothing is requested. The bench keeps every table and frame address inside its modelled window, so every read returns a defined word.

// File: rtl/vm_walker_pkg.sv
`timescale 1ns/1ps
package vm_walker_pkg;
   localparam int unsigned PTE_W      = 32;
   localparam int unsigned ENT_LG     = 2;   // log2 of bytes per entry
   localparam int unsigned BIT_VALID  = 0;
   localparam int unsigned BIT_DIRTY  = 1;
   localparam int unsigned BIT_WRITE  = 2;
   localparam int unsigned FLAG_W     = 3;

   typedef enum logic [2:0] {
      ST_IDLE, ST_RD1, ST_RD2, ST_WB, ST_REPORT
   } walk_st_e;

   typedef enum logic [1:0] {
      OUT_OK, OUT_ABSENT, OUT_DENIED
   } walk_out_e;
endpackage

// File: rtl/vm_walker_addr.sv
`timescale 1ns/1ps
module vm_walker_addr
   import vm_walker_pkg::*;
#(
   parameter int unsigned PA_W  = 30,
   parameter int unsigned L1_W  = 10,
   parameter int unsigned L2_W  = 10,
   parameter int unsigned OFS_W = 12,
   parameter int unsigned PPN_W = PA_W - OFS_W
) (
   input  logic             sel_lvl2,
   input  logic [PA_W-1:0]  base,
   input  logic [L1_W-1:0]  idx1,
   input  logic [L2_W-1:0]  idx2,
   input  logic [PPN_W-1:0] frame,
   output logic [PA_W-1:0]  addr
);
   logic [PA_W-1:0] l1_addr;
   logic [PA_W-1:0] l2_addr;

   // the root table may sit at any word boundary, so this one needs an adder
   assign l1_addr = base + PA_W'({idx1, {ENT_LG{1'b0}}});

   generate
      if (L2_W + ENT_LG == OFS_W) begin : g_l2_concat
         // a full second-level table fills its frame exactly: plain wiring
         assign l2_addr = {frame, idx2, {ENT_LG{1'b0}}};
      end else begin : g_l2_add
         assign l2_addr = {frame, {OFS_W{1'b0}}} + PA_W'({idx2, {ENT_LG{1'b0}}});
      end
   endgenerate

   assign addr = sel_lvl2 ? l2_addr : l1_addr;
endmodule

// File: rtl/vm_walker_pte.sv
`timescale 1ns/1ps
module vm_walker_pte
   import vm_walker_pkg::*;
(
   input  logic [FLAG_W-1:0] flags,
   input  logic              is_store,
   output logic              absent,
   output logic              denied,
   output logic              need_wb
);
   logic present, writable, dirty;

   assign present  = flags[BIT_VALID];
   assign writable = flags[BIT_WRITE];
   assign dirty    = flags[BIT_DIRTY];

   // absence outranks protection; write-back only for a permitted store
   assign absent  = !present;
   assign denied  = present && is_store && !writable;
   assign need_wb = present && is_store && writable && !dirty;
endmodule

// File: rtl/vm_walker_ctl.sv
`timescale 1ns/1ps
module vm_walker_ctl
   import vm_walker_pkg::*;
#(
   parameter int unsigned VA_W  = 32,
   parameter int unsigned PA_W  = 30,
   parameter int unsigned PPN_W = 18
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [VA_W-1:0]  req_va,
   input  logic             req_store,
   input  logic [PA_W-1:0]  tbl_base,
   input  logic             mem_ack,
   input  logic [PTE_W-1:0] mem_rdata,
   input  logic             dec_absent,
   input  logic             dec_denied,
   input  logic             dec_need_wb,
   output walk_st_e         st,
   output walk_out_e        outc,
   output logic [VA_W-1:0]  va_q,
   output logic             store_q,
   output logic [PA_W-1:0]  base_q,
   output logic [PPN_W-1:0] frame_q,
   output logic [PTE_W-1:0] leaf_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         outc    <= OUT_OK;
         va_q    <= '0;
         store_q <= 1'b0;
         base_q  <= '0;
         frame_q <= '0;
         leaf_q  <= '0;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (req_valid) begin
                  va_q    <= req_va;
                  store_q <= req_store;
                  base_q  <= tbl_base;
                  st      <= ST_RD1;
               end
            end
            ST_RD1: begin
               if (mem_ack) begin
                  if (dec_absent) begin
                     outc <= OUT_ABSENT;
                     st   <= ST_REPORT;
                  end else begin
                     frame_q <= mem_rdata[PTE_W-1 -: PPN_W];
                     st      <= ST_RD2;
                  end
               end
            end
            ST_RD2: begin
               if (mem_ack) begin
                  leaf_q <= mem_rdata;
                  if (dec_absent) begin
                     outc <= OUT_ABSENT;
                     st   <= ST_REPORT;
                  end else if (dec_denied) begin
                     outc <= OUT_DENIED;
                     st   <= ST_REPORT;
                  end else if (dec_need_wb) begin
                     st <= ST_WB;
                  end else begin
                     outc <= OUT_OK;
                     st   <= ST_REPORT;
                  end
               end
            end
            ST_WB: begin
               if (mem_ack) begin
                  leaf_q[BIT_DIRTY] <= 1'b1;
                  outc              <= OUT_OK;
                  st                <= ST_REPORT;
               end
            end
            ST_REPORT: st <= ST_IDLE;
            default:   st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/vm_walker.sv
`timescale 1ns/1ps
module vm_walker
   import vm_walker_pkg::*;
#(
   parameter int unsigned VA_W  = 32,
   parameter int unsigned PA_W  = 30,
   parameter int unsigned L1_W  = 10,
   parameter int unsigned L2_W  = 10,
   parameter int unsigned OFS_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [VA_W-1:0]  req_va,
   input  logic             req_store,
   input  logic [PA_W-1:0]  tbl_base,
   output logic             busy,
   output logic             mem_req,
   output logic             mem_we,
   output logic [PA_W-1:0]  mem_addr,
   output logic [PTE_W-1:0] mem_wdata,
   input  logic             mem_ack,
   input  logic [PTE_W-1:0] mem_rdata,
   output logic             done,
   output logic             fault_absent,
   output logic             fault_denied,
   output logic [PA_W-1:0]  pa,
   output logic             pte_dirty,
   output logic             pte_writable
);
   localparam int unsigned PPN_W = PA_W - OFS_W;
   localparam int unsigned L2_LO = OFS_W;
   localparam int unsigned L1_LO = OFS_W + L2_W;

   generate
      if (L1_W + L2_W + OFS_W != VA_W) begin : g_bad_split
         $error("index and offset widths must add up to VA_W");
      end
      if (PPN_W + FLAG_W > PTE_W) begin : g_bad_ppn
         $error("frame number and flags do not fit in one entry");
      end
      if (L2_W + ENT_LG > OFS_W) begin : g_bad_l2
         $error("second-level table overflows its frame");
      end
   endgenerate

   walk_st_e         st;
   walk_out_e        outc;
   logic [VA_W-1:0]  va_q;
   logic             store_q;
   logic [PA_W-1:0]  base_q;
   logic [PPN_W-1:0] frame_q;
   logic [PTE_W-1:0] leaf_q;
   logic             dec_absent, dec_denied, dec_need_wb;

   vm_walker_pte u_pte (
      .flags    (mem_rdata[FLAG_W-1:0]),
      .is_store (store_q),
      .absent   (dec_absent),
      .denied   (dec_denied),
      .need_wb  (dec_need_wb)
   );

   vm_walker_ctl #(.VA_W(VA_W), .PA_W(PA_W), .PPN_W(PPN_W)) u_ctl (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_va      (req_va),
      .req_store   (req_store),
      .tbl_base    (tbl_base),
      .mem_ack     (mem_ack),
      .mem_rdata   (mem_rdata),
      .dec_absent  (dec_absent),
      .dec_denied  (dec_denied),
      .dec_need_wb (dec_need_wb),
      .st          (st),
      .outc        (outc),
      .va_q        (va_q),
      .store_q     (store_q),
      .base_q      (base_q),
      .frame_q     (frame_q),
      .leaf_q      (leaf_q)
   );

   vm_walker_addr #(
      .PA_W(PA_W), .L1_W(L1_W), .L2_W(L2_W), .OFS_W(OFS_W), .PPN_W(PPN_W)
   ) u_addr (
      .sel_lvl2 (st != ST_RD1),
      .base     (base_q),
      .idx1     (va_q[L1_LO +: L1_W]),
      .idx2     (va_q[L2_LO +: L2_W]),
      .frame    (frame_q),
      .addr     (mem_addr)
   );

   assign busy         = (st != ST_IDLE);
   assign mem_req      = (st == ST_RD1) || (st == ST_RD2) || (st == ST_WB);
   assign mem_we       = (st == ST_WB);
   assign mem_wdata    = leaf_q | (PTE_W'(1) << BIT_DIRTY);
   assign done         = (st == ST_REPORT) && (outc == OUT_OK);
   assign fault_absent = (st == ST_REPORT) && (outc == OUT_ABSENT);
   assign fault_denied = (st == ST_REPORT) && (outc == OUT_DENIED);
   assign pa           = {leaf_q[PTE_W-1 -: PPN_W], va_q[OFS_W-1:0]};
   assign pte_dirty    = leaf_q[BIT_DIRTY];
   assign pte_writable = leaf_q[BIT_WRITE];
endmodule

// File: rtl/vm_walker_sva.sv
`timescale 1ns/1ps
module vm_walker_sva
   import vm_walker_pkg::*;
#(
   parameter int unsigned PA_W  = 30,
   parameter int unsigned OFS_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [OFS_W-1:0]  req_ofs,
   input logic              req_store,
   input logic              busy,
   input logic              mem_req,
   input logic              mem_we,
   input logic [PA_W-1:0]   mem_addr,
   input logic [FLAG_W-1:0] wd_flags,
   input logic              mem_ack,
   input logic              done,
   input logic              fault_absent,
   input logic              fault_denied,
   input logic [OFS_W-1:0]  pa_ofs,
   input logic              pte_dirty
);
   logic [OFS_W-1:0] ofs_cap;
   logic             store_cap;
   logic             wrote;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ofs_cap   <= '0;
         store_cap <= 1'b0;
         wrote     <= 1'b0;
      end else if (req_valid && !busy) begin
         ofs_cap   <= req_ofs;
         store_cap <= req_store;
         wrote     <= 1'b0;
      end else if (mem_req && mem_we) begin
         wrote <= 1'b1;
      end
   end

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req && !done && !fault_absent && !fault_denied);

   p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

   p_offset_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> pa_ofs == ofs_cap);

   p_denied_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fault_denied |-> !wrote);

   p_wb_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we |-> wd_flags[BIT_DIRTY] && wd_flags[BIT_VALID] && wd_flags[BIT_WRITE]);

   p_store_done_dirty_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done && store_cap |-> pte_dirty);

   p_one_outcome_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done, fault_absent, fault_denied}));

   p_outcome_ends_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done || fault_absent || fault_denied |=> !busy);
endmodule

bind vm_walker vm_walker_sva #(.PA_W(PA_W), .OFS_W(OFS_W)) u_sva (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_ofs      (req_va[OFS_W-1:0]),
   .req_store    (req_store),
   .busy         (busy),
   .mem_req      (mem_req),
   .mem_we       (mem_we),
   .mem_addr     (mem_addr),
   .wd_flags     (mem_wdata[vm_walker_pkg::FLAG_W-1:0]),
   .mem_ack      (mem_ack),
   .done         (done),
   .fault_absent (fault_absent),
   .fault_denied (fault_denied),
   .pa_ofs       (pa[OFS_W-1:0]),
   .pte_dirty    (pte_dirty)
);

// File: tb/sim_vm_walker.sv
`timescale 1ns/1ps
module sim_vm_walker;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_va = '0;
   logic        req_store = 1'b0;
   logic [29:0] tbl_base = '0;
   logic        busy, mem_req, mem_we;
   logic [29:0] mem_addr;
   logic [31:0] mem_wdata;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        done, fault_absent, fault_denied;
   logic [29:0] pa;
   logic        pte_dirty, pte_writable;

   int n_chk = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   vm_walker u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
      .req_store(req_store), .tbl_base(tbl_base), .busy(busy),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .done(done), .fault_absent(fault_absent), .fault_denied(fault_denied),
      .pa(pa), .pte_dirty(pte_dirty), .pte_writable(pte_writable)
   );

   // memory model: 8 KB window, one-cycle acknowledge, access log
   logic [31:0] mem [0:2047];
   int unsigned log_n = 0;
   logic [29:0] log_a [0:15];
   logic        log_w [0:15];
   logic [31:0] log_d [0:15];

   always @(posedge clk) begin
      if (!rst_n) begin
         mem_ack <= 1'b0;
      end else begin
         mem_ack <= mem_req && !mem_ack;
         if (mem_req && !mem_ack) begin
            mem_rdata <= mem[mem_addr[12:2]];
            if (mem_we) mem[mem_addr[12:2]] <= mem_wdata;
            log_a[log_n[3:0]] <= mem_addr;
            log_w[log_n[3:0]] <= mem_we;
            log_d[log_n[3:0]] <= mem_wdata;
            log_n <= log_n + 1;
         end
      end
   end

   function automatic logic [31:0] mk_pte(input logic [17:0] ppn, input bit w, input bit d, input bit v);
      return {ppn, 11'b0, w, d, v};
   endfunction

   function automatic logic [31:0] mk_va(input logic [9:0] i1, input logic [9:0] i2, input logic [11:0] off);
      return {i1, i2, off};
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // kind: 0 done, 1 absent, 2 denied, -1 timeout
   task automatic run_walk(input logic [31:0] va, input bit st, input logic [29:0] base,
                           output int kind, output logic [29:0] pa_o, output bit d_o,
                           output bit w_o, output int unsigned first);
      @(negedge clk);
      first = log_n;
      req_valid = 1'b1; req_va = va; req_store = st; tbl_base = base;
      @(negedge clk);
      req_valid = 1'b0;
      kind = -1;
      for (int i = 0; i < 60; i++) begin
         if (done) kind = 0;
         else if (fault_absent) kind = 1;
         else if (fault_denied) kind = 2;
         if (kind >= 0) break;
         @(negedge clk);
      end
      pa_o = pa; d_o = pte_dirty; w_o = pte_writable;
      if (kind < 0) chk(1'b0, "walk timeout", 0, 0);
   endtask

   task automatic t_reset();
      chk(!busy && !mem_req && !done && !fault_absent && !fault_denied, "R1 reset quiet",
          {busy, mem_req, done, fault_absent, fault_denied}, 0);
   endtask

   task automatic t_load_ro();
      int k; logic [29:0] p; bit d, w; int unsigned f;
      run_walk(mk_va(10'd3, 10'd5, 12'hABC), 1'b0, 30'h0, k, p, d, w, f);
      chk(k == 0, "R4 load outcome", k, 0);
      chk(p == {18'h2ABCD, 12'hABC}, "R4 pa", p, {18'h2ABCD, 12'hABC});
      chk(!d && !w, "R4 flags", {d, w}, 0);
      chk(log_a[f[3:0]] == 30'h00C, "R2 l1 addr", log_a[f[3:0]], 30'h00C);
      chk(log_a[f[3:0]+4'd1] == 30'h1014, "R3 l2 addr", log_a[f[3:0]+4'd1], 30'h1014);
      chk(log_n - f == 2 && !log_w[f[3:0]] && !log_w[f[3:0]+4'd1], "R9 load no write", log_n - f, 2);
      @(negedge clk);
      chk(!done && !busy, "R11 single-cycle outcome", {done, busy}, 0);
      chk(!mem_req, "R1 idle after walk", mem_req, 0);
   endtask

   task automatic t_base_offset();
      int k; logic [29:0] p; bit d, w; int unsigned f;
      run_walk(mk_va(10'd1, 10'd6, 12'h123), 1'b0, 30'h200, k, p, d, w, f);
      chk(log_a[f[3:0]] == 30'h204, "R2 base offset", log_a[f[3:0]], 30'h204);
      chk(log_a[f[3:0]+4'd1] == 30'h1018, "R3 l2 addr", log_a[f[3:0]+4'd1], 30'h1018);
      chk(k == 0 && p == {18'h15555, 12'h123} && w && !d, "R4 writable clean",
          {k[3:0], p, w, d}, {4'd0, 18'h15555, 12'h123, 2'b10});
   endtask

   task automatic t_l1_absent();
      int k; logic [29:0] p; bit d, w; int unsigned f;
      run_walk(mk_va(10'd4, 10'd5, 12'h0), 1'b0, 30'h0, k, p, d, w, f);
      chk(k == 1, "R5 l1 absent fault", k, 1);
      chk(log_n - f == 1, "R5 one access", log_n - f, 1);
   endtask

   task automatic t_l2_absent();
      int k; logic [29:0] p; bit d, w; int unsigned f;
      run_walk(mk_va(10'd3, 10'd8, 12'h0), 1'b1, 30'h0, k, p, d, w, f);
      chk(k == 1, "R6 l2 absent fault", k, 1);
      chk(log_n - f == 2 && !log_w[f[3:0]+4'd1], "R6 no write", log_n - f, 2);
   endtask

   task automatic t_store_ro();
      int k; logic [29:0] p; bit d, w; int unsigned f;
      run_walk(mk_va(10'd3, 10'd5, 12'h10), 1'b1, 30'h0, k, p, d, w, f);
      chk(k == 2, "R7 denied fault", k, 2);
      chk(log_n - f == 2, "R7 no write access", log_n - f, 2);
      chk(mem[11'h405] == mk_pte(18'h2ABCD, 0, 0, 1), "R7 entry unchanged", mem[11'h405], mk_pte(18'h2ABCD, 0, 0, 1));
   endtask

   task automatic t_store_clean();
      int k; logic [29:0] p; bit d, w; int unsigned f;
      logic [31:0] old;
      old = mem[11'h406];
      run_walk(mk_va(10'd3, 10'd6, 12'h44), 1'b1, 30'h0, k, p, d, w, f);
      chk(log_n - f == 3, "R8 three accesses", log_n - f, 3);
      chk(log_w[f[3:0]+4'd2] && log_a[f[3:0]+4'd2] == 30'h1018, "R8 write addr",
          {log_w[f[3:0]+4'd2], log_a[f[3:0]+4'd2]}, {1'b1, 30'h1018});
      chk(log_d[f[3:0]+4'd2] == (old | 32'h2), "R8 write data", log_d[f[3:0]+4'd2], old | 32'h2);
      chk(k == 0 && d && p == {18'h15555, 12'h044}, "R8 done dirty", {k[3:0], d, p}, {4'd0, 1'b1, 18'h15555, 12'h044});
      // same page again: now dirty, no second write
      run_walk(mk_va(10'd3, 10'd6, 12'h48), 1'b1, 30'h0, k, p, d, w, f);
      chk(log_n - f == 2 && k == 0 && d, "R9 store to now-dirty page", log_n - f, 2);
   endtask

   task automatic t_store_dirty();
      int k; logic [29:0] p; bit d, w; int unsigned f;
      run_walk(mk_va(10'd3, 10'd7, 12'hFFF), 1'b1, 30'h0, k, p, d, w, f);
      chk(log_n - f == 2, "R9 dirty store no write", log_n - f, 2);
      chk(k == 0 && d && w && p == {18'h0F0F0, 12'hFFF}, "R9 dirty store result", p, {18'h0F0F0, 12'hFFF});
   endtask

   task automatic t_busy_ignore();
      int k; int unsigned f;
      @(negedge clk);
      f = log_n;
      req_valid = 1'b1; req_va = mk_va(10'd3, 10'd7, 12'h5); req_store = 1'b0; tbl_base = 30'h0;
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
      req_valid = 1'b1; req_va = mk_va(10'd4, 10'd0, 12'h0); req_store = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      k = -1;
      for (int i = 0; i < 60; i++) begin
         if (done) k = 0;
         else if (fault_absent || fault_denied) k = 1;
         if (k >= 0) break;
         @(negedge clk);
      end
      chk(k == 0 && pa == {18'h0F0F0, 12'h005}, "R10 first walk unchanged", pa, {18'h0F0F0, 12'h005});
      repeat (6) @(negedge clk);
      chk(!busy && log_n - f == 2, "R10 no extra walk", log_n - f, 2);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      for (int i = 0; i < 2048; i++) mem[i] = '0;
      mem[11'h003] = mk_pte(18'h1, 0, 0, 1);
      mem[11'h081] = mk_pte(18'h1, 0, 0, 1);
      mem[11'h405] = mk_pte(18'h2ABCD, 0, 0, 1);
      mem[11'h406] = mk_pte(18'h15555, 1, 0, 1);
      mem[11'h407] = mk_pte(18'h0F0F0, 1, 1, 1);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_load_ro();
      t_base_offset();
      t_l1_absent();
      t_l2_absent();
      t_store_ro();
      t_store_clean();
      t_store_dirty();
      t_busy_ignore();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule